// File: doc/BRIEF.md
# Pulse-Timed Byte Programming Sequencer with Irreversible Lock Bits

This block carries out one byte-programming operation at a time on a small nonvolatile-style array. Every byte has a companion lock bit that can only go from 1 to 0. The serial front end hands over an already decoded operation: an opcode, a byte address and a data byte. The block has no timer of its own. It counts the slow clock pulses that the host supplies on `card_clk`, and that count alone picks the kind of change made to the byte. Enough pulses for one phase give an erase-only or a clear-only change. Enough pulses for two phases give an erase followed by a write.

The operation ends when the host raises `card_rst`. At that moment the new byte and lock bit are written together, or nothing is written at all if too few pulses arrived. The status line `io_out` drops to 0 once the one-phase pulse count has been reached. It returns to 1 only on a rising edge of `card_rst`. A second read port lets the front end read any byte and its lock bit with one cycle of latency. The array is built as plain memory so that block RAM can be inferred.

Top module: `pgm_seq_top`

## Requirements
- R1: Reset sets `io_out` to 1 and the sequencer idle. The array contents are not touched by reset; at power-up every byte reads FFh with lock bit 1, and `rd_data`/`rd_prot` show the location at `rd_addr` one clock later.
- R2: If `cmd` is 0 (write) or 1 (write-and-lock), the target is unlocked, and at least 203 `card_clk` pulses were counted before the `card_rst` rise, the byte becomes the input data (erase then write).
- R3: If the pulse count is 103 to 202 and the input data is not FFh, a write or write-and-lock stores the bitwise AND of the old byte and the input data.
- R4: If the pulse count is 103 to 202 and the input data is FFh, a write or write-and-lock stores FFh (erase only).
- R5: If `card_rst` rises after fewer than 103 counted pulses, the operation is dropped and both the byte and its lock bit stay as they were.
- R6: A byte whose lock bit is 0 keeps its value and its lock bit under every opcode and every pulse count.
- R7: A write-and-lock (`cmd` 1) that completes on an unlocked byte also clears that byte's lock bit. No operation ever sets a lock bit back to 1.
- R8: A compare-and-lock (`cmd` 2) with at least 103 pulses clears the lock bit only when the input data equals the stored byte. The byte itself is never changed, and on a mismatch nothing changes.
- R9: `io_out` falls to 0 in the cycle after the 103rd counted pulse. It stays 0 until `card_rst` rises, and is 1 in the cycle after that rise.
- R10: `card_clk` pulses while idle, `cmd_valid` while an operation is in progress, and opcode 3 all have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: start an operation (taken only when idle) |
| cmd | input | 2 | Opcode: 0 write, 1 write-and-lock, 2 compare-and-lock, 3 no-op |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | DATA_W | Input data byte |
| card_clk | input | 1 | One-cycle strobe per host programming clock pulse |
| card_rst | input | 1 | Host reset line level; its rising edge ends the operation |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | DATA_W | Byte at `rd_addr`, one cycle late |
| rd_prot | output | 1 | Lock bit at `rd_addr`, one cycle late (0 = locked) |
| io_out | output | 1 | Status line: 0 once the one-phase count is reached |

## Verification
The hardest situation to reach is a byte that is already locked and then receives a full-length write. Reaching it needs a whole earlier write-and-lock or a matching compare-and-lock of 103 or more pulses, and only after that can the bench show that the later write leaves the byte alone. The bench gets there in stages over every address. It first gives each address known contents. It then locks selected addresses with write-and-lock and with a matching compare-and-lock, and leaves others unlocked after a mismatched compare. Finally it runs long writes, and write-and-lock operations of medium length, across the whole array. Sixteen addresses cover locked and unlocked bytes side by side. Pulse counts around the 103 boundary and the 203 boundary pick out each kind of change.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE      = 2'd0,
    CMD_WRITE_LOCK = 2'd1,
    CMD_LOCK_CMP   = 2'd2,
    CMD_NONE       = 2'd3
  } pgm_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } pgm_state_e;
endpackage

// File: rtl/pgm_pulse_counter.sv
module pgm_pulse_counter #(
  parameter int LIMIT = 203,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             pulse,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (pulse && cnt != CAP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pgm_cell_array.sv
module pgm_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_prot,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_data,
  output logic              a_prot,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data,
  output logic              b_prot
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic              locks [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cells[i] = '1;
      locks[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    a_data <= cells[a_addr];
    b_data <= cells[b_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) locks[wr_addr] <= wr_prot;
    a_prot <= locks[a_addr];
    b_prot <= locks[b_addr];
  end
endmodule

// File: rtl/pgm_outcome.sv
module pgm_outcome
  import pgm_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  pgm_cmd_e          op,
  input  logic [DATA_W-1:0] old_data,
  input  logic              old_prot,
  input  logic [DATA_W-1:0] in_data,
  input  logic              long_form,
  output logic [DATA_W-1:0] new_data,
  output logic              new_prot
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  always_comb begin
    new_data = old_data;
    new_prot = old_prot;
    if (old_prot) begin
      unique case (op)
        CMD_WRITE, CMD_WRITE_LOCK: begin
          if (long_form)              new_data = in_data;
          else if (in_data == ALL_ONES) new_data = ALL_ONES;
          else                        new_data = old_data & in_data;
          if (op == CMD_WRITE_LOCK)   new_prot = 1'b0;
        end
        CMD_LOCK_CMP: begin
          if (in_data == old_data) new_prot = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgm_seq_top.sv
module pgm_seq_top
  import pgm_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PHASE_CLKS = 100,
  parameter int ENTRY_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              card_clk,
  input  logic              card_rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_prot,
  output logic              io_out
);
  localparam int SHORT_CNT = PHASE_CLKS + ENTRY_CLKS;
  localparam int LONG_CNT  = 2 * PHASE_CLKS + ENTRY_CLKS;
  localparam int CNT_W     = $clog2(LONG_CNT + 1);

  pgm_state_e        state;
  pgm_cmd_e          op_cmd;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] old_data;
  logic              old_prot;
  logic [DATA_W-1:0] fetch_data;
  logic              fetch_prot;
  logic              card_rst_q;
  logic              io_q;
  logic [CNT_W-1:0]  cnt;
  logic              rst_rise;
  logic              running;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              wr_prot;

  assign rst_rise = card_rst && !card_rst_q;
  assign running  = (state == ST_RUN);
  assign wr_en    = running && rst_rise && (cnt >= CNT_W'(SHORT_CNT));
  assign io_out   = io_q;

  pgm_pulse_counter #(.LIMIT(LONG_CNT)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (!running),
    .pulse (running && card_clk),
    .cnt   (cnt)
  );

  pgm_outcome #(.DATA_W(DATA_W)) u_outcome (
    .op        (op_cmd),
    .old_data  (old_data),
    .old_prot  (old_prot),
    .in_data   (op_data),
    .long_form (cnt >= CNT_W'(LONG_CNT)),
    .new_data  (wr_data),
    .new_prot  (wr_prot)
  );

  pgm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (op_addr),
    .wr_data (wr_data),
    .wr_prot (wr_prot),
    .a_addr  (cmd_addr),
    .a_data  (fetch_data),
    .a_prot  (fetch_prot),
    .b_addr  (rd_addr),
    .b_data  (rd_data),
    .b_prot  (rd_prot)
  );

  always_ff @(posedge clk) card_rst_q <= card_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_cmd   <= CMD_NONE;
      op_addr  <= '0;
      op_data  <= '0;
      old_data <= '0;
      old_prot <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          op_cmd  <= pgm_cmd_e'(cmd);
          op_addr <= cmd_addr;
          op_data <= cmd_data;
          state   <= ST_FETCH;
        end
        ST_FETCH: begin
          old_data <= fetch_data;
          old_prot <= fetch_prot;
          state    <= rst_rise ? ST_IDLE : ST_RUN;
        end
        ST_RUN: if (rst_rise) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_q <= 1'b1;
    else if (rst_rise) io_q <= 1'b1;
    else if (running && card_clk && cnt == CNT_W'(SHORT_CNT - 1)) io_q <= 1'b0;
  end
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int DATA_W = 8,
  parameter int SHORT  = 103,
  parameter int LONG   = 203,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              card_rst,
  input logic              io_out,
  input logic [CNT_W-1:0]  cnt,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_prot,
  input logic [DATA_W-1:0] old_data,
  input logic              old_prot
);
  AST_IO_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(card_rst) |=> io_out); // R9
  AST_IO_HOLD_LOW: assert property (@(posedge clk) disable iff (rst) (!io_out && !$rose(card_rst)) |=> !io_out); // R9
  AST_IO_FALL_AT_SHORT: assert property (@(posedge clk) disable iff (rst) $fell(io_out) |-> (cnt == CNT_W'(SHORT))); // R9
  AST_LOCKED_UNCHANGED: assert property (@(posedge clk) disable iff (rst) (wr_en && !old_prot) |-> (!wr_prot && wr_data == old_data)); // R6
  AST_LOCK_MONOTONIC: assert property (@(posedge clk) disable iff (rst) wr_en |-> (!wr_prot || old_prot)); // R7
  AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(LONG)); // R2
endmodule

bind pgm_seq_top pgm_seq_chk #(
  .DATA_W (DATA_W),
  .SHORT  (SHORT_CNT),
  .LONG   (LONG_CNT),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .card_rst (card_rst),
  .io_out   (io_out),
  .cnt      (cnt),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_prot  (wr_prot),
  .old_data (old_data),
  .old_prot (old_prot)
);

// File: tb/test_pgm_seq_top.sv
`timescale 1ns/1ps
module test_pgm_seq_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int SHORT = 103;
  localparam int LONG  = 203;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          card_clk = 1'b0;
  logic          card_rst = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_prot;
  logic          io_out;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] m_data [N];
  logic          m_prot [N];

  always #2.5 clk = ~clk;

  pgm_seq_top #(.ADDR_W(AW), .DATA_W(DW)) i_pgm_seq_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .card_clk(card_clk), .card_rst(card_rst),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_prot(rd_prot), .io_out(io_out)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) begin
      @(negedge clk) rd_addr = AW'(i);
      @(negedge clk);
      check(tag, $sformatf("data[%0d]", i), 32'(rd_data), 32'(m_data[i]));
      check(tag, $sformatf("lock[%0d]", i), 32'(rd_prot), 32'(m_prot[i]));
    end
  endtask

  function automatic void model(input int c, input int a, input logic [DW-1:0] d, input int n);
    if (n < SHORT || !m_prot[a]) return;
    if (c == 0 || c == 1) begin
      if (n >= LONG) m_data[a] = d;
      else if (d == 8'hFF) m_data[a] = 8'hFF;
      else m_data[a] = m_data[a] & d;
      if (c == 1) m_prot[a] = 1'b0;
    end else if (c == 2) begin
      if (d == m_data[a]) m_prot[a] = 1'b0;
    end
  endfunction

  task automatic do_op(input int c, input int a, input logic [DW-1:0] d, input int n, input bit inject);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'(c); cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk) cmd_valid = 1'b0;
    @(negedge clk);
    for (int k = 1; k <= n; k++) begin
      card_clk = 1'b1;
      if (inject && k == 10) begin
        cmd_valid = 1'b1; cmd = 2'd0; cmd_addr = AW'(a + 8); cmd_data = 8'h00;
      end
      @(negedge clk);
      card_clk = 1'b0; cmd_valid = 1'b0;
      if (k == SHORT - 1) check("R9", "io before 103rd pulse", 32'(io_out), 32'd1);
      if (k == SHORT)     check("R9", "io after 103rd pulse", 32'(io_out), 32'd0);
      @(negedge clk);
    end
    if (n < SHORT) check("R9", "io stays high on short run", 32'(io_out), 32'd1);
    card_rst = 1'b1;
    @(negedge clk);
    check("R9", "io released after rst rise", 32'(io_out), 32'd1);
    @(negedge clk) card_rst = 1'b0;
    @(negedge clk);
    model(c, a, d, n);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_data[i] = 8'hFF;
      m_prot[i] = 1'b1;
    end
    repeat (4) @(negedge clk);
    check("R1", "io during reset", 32'(io_out), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "io after reset", 32'(io_out), 32'd1);
    check_all("R1");

    // R10: pulses while idle, then an rst edge, change nothing
    for (int k = 0; k < 250; k++) begin
      @(negedge clk) card_clk = 1'b1;
      @(negedge clk) card_clk = 1'b0;
    end
    @(negedge clk) card_rst = 1'b1;
    @(negedge clk) card_rst = 1'b0;
    @(negedge clk);
    check("R10", "io after idle pulses", 32'(io_out), 32'd1);
    check_all("R10");

    for (int a = 0; a < N; a++) do_op(0, a, DW'(a * 17) ^ 8'h5A, LONG, 1'b0);
    check_all("R2");

    for (int a = 0; a < N; a++) do_op(0, a, ~DW'(1 << (a % 8)), SHORT + a, 1'b0);
    check_all("R3");

    for (int a = 0; a < N; a += 2) do_op(0, a, 8'hFF, 150, 1'b0);
    check_all("R4");

    for (int a = 0; a < N; a++) do_op(0, a, 8'h00, a * 6, 1'b0);
    do_op(1, 1, 8'h00, SHORT - 1, 1'b0);
    check_all("R5");

    for (int a = 0; a < N; a++) begin
      if (a % 4 == 0) do_op(1, a, DW'(a) | 8'hA0, LONG, 1'b0);
      if (a % 4 == 1) do_op(2, a, m_data[a], SHORT, 1'b0);
      if (a % 4 == 2) do_op(2, a, m_data[a] ^ 8'h01, LONG, 1'b0);
    end
    check_all("R7 R8");

    for (int a = 0; a < N; a++) do_op(0, a, 8'h3C, LONG, 1'b0);
    for (int a = 0; a < N; a += 3) do_op(1, a, 8'hFF, 120, 1'b0);
    check_all("R6");

    do_op(3, 5, 8'h00, LONG, 1'b0);
    do_op(0, 3, 8'h11, LONG, 1'b1);
    check_all("R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule